// File: doc/BRIEF.md
# Key-Protected Core Clock Divider Control

This block holds the power and clock control word of a chip and turns it into a core-clock enable. Software reaches the block over a small write bus: an address, a byte of data and a write strobe. The bus addresses three locations. Two of them are key locations. The third holds the protected control word. The control word changes only when three bus writes arrive in a fixed order. The first is the opening key value at the first key location. The second is the new word at the control location. The third is the closing key value at the second key location. If the order is broken in any way, the staged word is discarded.

The control word has two fields. Bits [2:0] hold the divider exponent. Bits [6:3] hold the power mode. The block produces `core_en`, which is high for one system-clock cycle out of every 2^exponent cycles, so it serves as the enable of the divided core clock. It also raises `nap_req` when the committed mode is the nap code. A new exponent is applied only when the current enable period ends, so a divider change never shortens a period. The live control word is always readable on `ctl_rdata`.

Top module: `keyed_clk_ctl`

## Requirements
- R1: After reset, `ctl_rdata` reads 0x7B: exponent 3, mode field 4'b1111, bit 7 zero. `div_now` reads 3, and `core_en` is first high on the 8th rising edge after reset release and then once every 8 cycles.
- R2: The locations are at fixed addresses: opening key at address 0, control at address 1, closing key at address 2. A new word is committed only when three consecutive bus writes occur in this order: value 0x01 to address 0, any value to address 1, value 0xF4 to address 2. Cycles with no write between them are allowed. The committed word is visible on the cycle after the closing-key write.
- R3: `ctl_rdata` always shows the live word, never a staged one. Bit 7 of a written control value is ignored and always reads 0.
- R4: The sequence aborts and the live word stays unchanged in three cases: a write to any other address, or to the wrong location, comes between the three writes; the opening key is written with a value other than 0x01; the closing key is written with a value other than 0xF4.
- R5: A correct opening-key write always starts a fresh sequence. This holds even in the middle of a sequence, and the earlier staged value is dropped.
- R6: `core_en` is high for exactly one cycle in every 2^E cycles, where E is the applied exponent (`div_now`).
- R7: A committed exponent is copied to `div_now` only on a cycle in which `core_en` is high. The running period completes at the old rate.
- R8: `nap_req` is high exactly when the live mode field (bits [6:3]) equals 4'b1110. A committed 0x73 gives nap with exponent 3.
- R9: Committing 0x78 gives exponent 0. After the next period boundary, `core_en` is high on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Write address (0 opening key, 1 control, 2 closing key) |
| bus_wdata | input | 8 | Write data |
| ctl_rdata | output | 8 | Live control word |
| div_now | output | 3 | Exponent currently applied by the divider |
| core_en | output | 1 | Core-clock enable pulse |
| nap_req | output | 1 | Nap mode requested |

## Verification
The bench covers several ways to break the unlock sequence:
- A stray write between the keys. A design that only counts key writes would commit here.
- A wrong value at either key.
- A restarted sequence. A design that keeps the first staged word would commit stale data.
- Idle gaps inside a correct sequence. A design that needs strictly adjacent cycles would drop a legal unlock.

A read taken between the control and closing-key writes shows whether a staged word leaks to the read port. The exponent is changed in the middle of a period. A design that switches at once would emit a shortened pulse and move `div_now` off a boundary. The bench also writes a control value with bit 7 set, to show whether that bit is stored.

// File: rtl/clkkey_pkg.sv
package clkkey_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE   = 2'd0,
      SEQ_ARMED  = 2'd1,
      SEQ_STAGED = 2'd2
   } seq_state_e;
endpackage

// File: rtl/clkkey_seq.sv
module clkkey_seq
   import clkkey_pkg::*;
#(
   parameter int AW      = 2,
   parameter int DW      = 8,
   parameter int CTL_W   = 7,
   parameter int ADR_K1  = 0,
   parameter int ADR_CTL = 1,
   parameter int ADR_K2  = 2,
   parameter int KEY_OPEN  = 8'h01,
   parameter int KEY_CLOSE = 8'hF4,
   parameter int RST_WORD  = 7'h7B
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [AW-1:0]    addr,
   input  logic [DW-1:0]    wdata,
   output logic [CTL_W-1:0] live_word
);
   seq_state_e       st_q, st_d;
   logic [CTL_W-1:0] stage_q, stage_d;
   logic [CTL_W-1:0] live_q, live_d;
   logic             hit_open, hit_ctl, hit_close;

   assign hit_open  = wr && (addr == AW'(ADR_K1))  && (wdata == DW'(KEY_OPEN));
   assign hit_ctl   = wr && (addr == AW'(ADR_CTL));
   assign hit_close = wr && (addr == AW'(ADR_K2))  && (wdata == DW'(KEY_CLOSE));

   always_comb begin
      st_d    = st_q;
      stage_d = stage_q;
      live_d  = live_q;
      if (wr) begin
         st_d = hit_open ? SEQ_ARMED : SEQ_IDLE;
         unique case (st_q)
            SEQ_ARMED: begin
               if (hit_ctl) begin
                  st_d    = SEQ_STAGED;
                  stage_d = wdata[CTL_W-1:0];
               end
            end
            SEQ_STAGED: begin
               if (hit_close) live_d = stage_q;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= SEQ_IDLE;
         stage_q <= '0;
         live_q  <= CTL_W'(RST_WORD);
      end else begin
         st_q    <= st_d;
         stage_q <= stage_d;
         live_q  <= live_d;
      end
   end

   assign live_word = live_q;
endmodule

// File: rtl/clkkey_div.sv
module clkkey_div #(
   parameter int EXP_W   = 3,
   parameter int RST_EXP = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [EXP_W-1:0] exp_req,
   output logic [EXP_W-1:0] exp_now,
   output logic             tick
);
   localparam int CNT_W = (1 << EXP_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;
   logic [EXP_W-1:0] exp_q;

   for (genvar i = 0; i < CNT_W; i++) begin : g_mask
      assign limit[i] = (i < int'(exp_q));
   end

   assign tick = (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= EXP_W'(RST_EXP);
      end else if (tick) begin
         cnt_q <= '0;
         exp_q <= exp_req;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign exp_now = exp_q;
endmodule

// File: rtl/keyed_clk_ctl.sv
module keyed_clk_ctl #(
   parameter int AW        = 2,
   parameter int DW        = 8,
   parameter int EXP_W     = 3,
   parameter int MODE_W    = 4,
   parameter int ADR_K1    = 0,
   parameter int ADR_CTL   = 1,
   parameter int ADR_K2    = 2,
   parameter int KEY_OPEN  = 8'h01,
   parameter int KEY_CLOSE = 8'hF4,
   parameter int NAP_CODE  = 4'hE,
   parameter int RST_WORD  = 7'h7B
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_wr,
   input  logic [AW-1:0]    bus_addr,
   input  logic [DW-1:0]    bus_wdata,
   output logic [DW-1:0]    ctl_rdata,
   output logic [EXP_W-1:0] div_now,
   output logic             core_en,
   output logic             nap_req
);
   localparam int CTL_W = EXP_W + MODE_W;

   if (CTL_W > DW) begin : g_bad_width
      $error("control word wider than bus");
   end
   if (KEY_OPEN == KEY_CLOSE) begin : g_bad_keys
      $error("key values must differ");
   end

   logic [CTL_W-1:0] live_word;

   clkkey_seq #(
      .AW(AW), .DW(DW), .CTL_W(CTL_W),
      .ADR_K1(ADR_K1), .ADR_CTL(ADR_CTL), .ADR_K2(ADR_K2),
      .KEY_OPEN(KEY_OPEN), .KEY_CLOSE(KEY_CLOSE), .RST_WORD(RST_WORD)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .live_word(live_word)
   );

   clkkey_div #(
      .EXP_W(EXP_W), .RST_EXP(RST_WORD % (1 << EXP_W))
   ) u_div (
      .clk(clk), .rst_n(rst_n), .exp_req(live_word[EXP_W-1:0]),
      .exp_now(div_now), .tick(core_en)
   );

   if (CTL_W < DW) begin : g_pad
      assign ctl_rdata = {{(DW-CTL_W){1'b0}}, live_word};
   end else begin : g_full
      assign ctl_rdata = live_word;
   end

   assign nap_req = (live_word[CTL_W-1:EXP_W] == MODE_W'(NAP_CODE));
endmodule

// File: rtl/keyed_clk_ctl_chk.sv
module keyed_clk_ctl_chk #(
   parameter int AW = 2, parameter int DW = 8, parameter int EXP_W = 3,
   parameter int ADR_K2 = 2, parameter int KEY_CLOSE = 8'hF4, parameter int NAP_CODE = 4'hE
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [AW-1:0]    bus_addr,
   input logic [DW-1:0]    bus_wdata,
   input logic [DW-1:0]    ctl_rdata,
   input logic [EXP_W-1:0] div_now,
   input logic             core_en,
   input logic             nap_req
);
   p_live_needs_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr && bus_addr == AW'(ADR_K2) && bus_wdata == DW'(KEY_CLOSE)) |=> $stable(ctl_rdata));
   p_bit7_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_rdata[DW-1] == 1'b0);
   p_no_double_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
      core_en |=> (div_now == '0 || !core_en));
   p_exp_at_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !core_en |=> $stable(div_now));
   p_nap_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      nap_req |-> ctl_rdata[EXP_W+3:EXP_W] == 4'(NAP_CODE));
endmodule

bind keyed_clk_ctl keyed_clk_ctl_chk #(
   .AW(AW), .DW(DW), .EXP_W(EXP_W), .ADR_K2(ADR_K2), .KEY_CLOSE(KEY_CLOSE), .NAP_CODE(NAP_CODE)
) u_chk (.*);

// File: tb/sim_keyed_clk_ctl.sv
module sim_keyed_clk_ctl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [1:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] ctl_rdata;
   logic [2:0] div_now;
   logic       core_en, nap_req;

   int checks = 0, errors = 0, cyc = 0;
   int m_seq = 0, m_stage = 0, m_live = 'h7B, m_exp = 3, m_cnt = 0;
   bit model_on = 1'b0;

   always #5 clk = ~clk;

   keyed_clk_ctl u0 (.*);

   // behavioural reference, updated on every rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_seq = 0; m_stage = 0; m_live = 'h7B; m_exp = 3; m_cnt = 0;
      end else begin
         if (m_cnt == (1 << m_exp) - 1) begin
            m_cnt = 0; m_exp = m_live & 7;
         end else m_cnt++;
         if (bus_wr) begin
            automatic bit opener = (bus_addr == 0 && bus_wdata == 8'h01);
            if (m_seq == 1 && bus_addr == 1) begin
               m_stage = bus_wdata & 'h7F; m_seq = 2;
            end else begin
               if (m_seq == 2 && bus_addr == 2 && bus_wdata == 8'hF4) m_live = m_stage;
               m_seq = opener ? 1 : 0;
            end
         end
      end
   end

   task automatic check(string req, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   always @(negedge clk) if (model_on) begin
      check("R6 core_en", core_en, m_cnt == (1 << m_exp) - 1);
      check("R3 ctl_rdata", ctl_rdata, m_live);
      check("R7 div_now", div_now, m_exp);
      check("R8 nap_req", nap_req, ((m_live >> 3) & 15) == 14);
   end

   task automatic finish_up;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   always @(posedge clk) if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: got %0d expected below 20000", cyc);
      finish_up();
   end

   task automatic put(int a, int d);
      bus_wr = 1'b1; bus_addr = 2'(a); bus_wdata = 8'(d);
      @(negedge clk);
   endtask

   task automatic idle(int n);
      bus_wr = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   task automatic unlock(int v);
      put(0, 'h01); put(1, v); put(2, 'hF4); idle(1);
   endtask

   initial begin
      int pulses;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R1 reset word", ctl_rdata, 'h7B);
      check("R1 reset exponent", div_now, 3);
      model_on = 1'b1;
      pulses = 0;
      for (int i = 1; i <= 8; i++) begin
         @(negedge clk);
         if (core_en) pulses++;
         if (i < 7) check("R1 no early pulse", core_en, 0);
      end
      check("R1 first pulse", pulses, 1);
      pulses = 0;
      for (int i = 0; i < 32; i++) begin
         @(negedge clk);
         if (core_en) pulses++;
      end
      check("R6 pulse count div8", pulses, 4);

      // mid-period change: wait for a boundary, then two cycles
      while (!core_en) @(negedge clk);
      idle(2);
      put(0, 'h01); put(1, 'h78); put(2, 'hF4); idle(0);
      check("R2 commit visible", ctl_rdata, 'h78);
      check("R7 old exponent held", div_now, 3);
      while (!core_en) @(negedge clk);
      idle(1);
      check("R9 exponent zero", div_now, 0);
      pulses = 0;
      for (int i = 0; i < 10; i++) begin
         if (core_en) pulses++;
         @(negedge clk);
      end
      check("R9 pulse every cycle", pulses, 10);

      // gaps allowed, staged value hidden
      put(0, 'h01); idle(2); put(1, 'h05); idle(3);
      check("R3 staged hidden", ctl_rdata, 'h78);
      put(2, 'hF4); idle(1);
      check("R2 commit with gaps", ctl_rdata, 'h05);

      // aborts
      put(0, 'h01); put(1, 'h73); put(3, 'h00); put(2, 'hF4); idle(1);
      check("R4 stray write", ctl_rdata, 'h05);
      put(0, 'h02); put(1, 'h73); put(2, 'hF4); idle(1);
      check("R4 bad opening key", ctl_rdata, 'h05);
      put(0, 'h01); put(1, 'h73); put(2, 'hF5); idle(1);
      check("R4 bad closing key", ctl_rdata, 'h05);
      put(0, 'h01); put(2, 'hF4); put(1, 'h73); idle(1);
      check("R4 wrong order", ctl_rdata, 'h05);
      check("R8 no nap", nap_req, 0);

      // re-arm drops earlier staged value
      put(0, 'h01); put(1, 'h10); put(0, 'h01); put(1, 'h73); put(2, 'hF4); idle(1);
      check("R5 re-armed commit", ctl_rdata, 'h73);
      check("R8 nap requested", nap_req, 1);
      idle(40);

      // bit 7 ignored
      unlock('hFB);
      check("R3 bit7 dropped", ctl_rdata, 'h7B);
      check("R8 nap released", nap_req, 0);
      idle(40);
      model_on = 1'b0;
      finish_up();
   end
endmodule